// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 32-bit instruction word of a small load/store instruction set into the control signals and operand fields that a single-issue datapath needs. There are three layouts. A register-format word names two sources, a destination and a shift amount, and uses a secondary function field to pick the operation. An immediate-format word carries two register specifiers and a 16-bit constant or offset. A jump-format word carries a 26-bit target. All three layouts share a 6-bit opcode in the top bits.

The decoder is purely combinational, so its outputs follow the instruction word within the same cycle. It drives the following outputs: register write enable, the final write address (rd, rt or the link register), ALU source select, ALU operation, memory read and write, load-to-register select, branch and branch-on-not-equal, jump, link and jump-through-register. It also drives the 32-bit extended immediate. Any opcode or function value outside the supported set raises `illegal_o` and holds every control with a side effect low.

Top module: `instr_decoder`

## Requirements
- R1: Field extraction is the same for every opcode. `rs_o`=instr[25:21], `rt_o`=instr[20:16], `rd_o`=instr[15:11], `shamt_o`=instr[10:6] and `jtarget_o`=instr[25:0]. `wr_addr_o` is rd when the opcode is 0, register 31 when the opcode is 3, and rt otherwise.
- R2: Opcode 0 selects the register format, with the function code in instr[5:0]. For the function codes add 32, sub 34, and 36, or 37, nor 39, slt 42, sll 0 and srl 2, the decoder sets `reg_we_o`=1 and `alu_src_imm_o`=0 and leaves all memory, branch and jump controls low. `alu_op_o` takes the values ADD=0, SUB=1, AND=2, OR=3, NOR=4, SLT=5, SLL=6, SRL=7.
- R3: For the immediate-format opcodes, the decoder sets `reg_we_o`=1 and `alu_src_imm_o`=1 and writes rt. The opcodes and their `alu_op_o` values are addi 8 (ADD), slti 10 (SLT), andi 12 (AND), ori 13 (OR) and lui 15 (PASS=8).
- R4: `imm_o` zero-extends instr[15:0] for andi and ori. For lui it places instr[15:0] in the upper half with zeros below. For every other opcode it sign-extends instr[15:0].
- R5: Load word (opcode 35) sets `mem_rd_o`, `mem_to_reg_o` and `reg_we_o`, with an ADD on the immediate. Store word (opcode 43) sets `mem_wr_o` with an ADD on the immediate, and sets `reg_we_o`=0.
- R6: beq (opcode 4) and bne (opcode 5) set `branch_o`, with a SUB on two registers and no writes. `branch_ne_o` is 1 only for bne.
- R7: j (opcode 2) sets only `jump_o`. jal (opcode 3) sets `jump_o`, `link_o` and `reg_we_o`, with write address 31.
- R8: Opcode 0 with function code 8 sets only `jump_reg_o` and writes nothing.
- R9: When the write address is 0, `reg_we_o` is 0 even for an instruction that writes a register. The other controls are unchanged and the instruction is not illegal.
- R10: Any other opcode, or opcode 0 with any other function code, sets `illegal_o`=1. In that case `reg_we_o`, `mem_wr_o`, `mem_rd_o`, `branch_o`, `jump_o`, `link_o`, `jump_reg_o` and `alu_src_imm_o` are 0 and `alu_op_o` is ADD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs_o | output | 5 | First source register specifier |
| rt_o | output | 5 | Second source / immediate-format destination specifier |
| rd_o | output | 5 | Register-format destination field |
| shamt_o | output | 5 | Shift amount field |
| jtarget_o | output | 26 | Jump target field |
| imm_o | output | 32 | Extended immediate |
| wr_addr_o | output | 5 | Selected register write address |
| reg_we_o | output | 1 | Register file write enable |
| alu_src_imm_o | output | 1 | ALU second operand is the immediate |
| alu_op_o | output | 4 | ALU operation code |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| mem_to_reg_o | output | 1 | Write-back data comes from memory |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch condition is not-equal |
| jump_o | output | 1 | Direct jump |
| link_o | output | 1 | Save return address in link register |
| jump_reg_o | output | 1 | Jump through register |
| illegal_o | output | 1 | Undefined opcode or function code |

## Verification
The bench targets the boundaries of immediate extension: offsets with bit 15 set, the zero-extending logical forms and lui. A decoder with the wrong extension rule would hand back a negative mask or a positive offset. It also covers destinations of register 0, where a missing guard would corrupt the constant-zero register and a too-eager guard would flag a legal instruction as illegal. Undefined opcodes and function codes are tested to show that no write, memory access or jump escapes. The link and jump-register cases are checked for the wrong destination, or for a write where none should happen.

// File: rtl/ifd_pkg.sv
// Package: shared widths, opcode/function encodings, ALU codes and the
// control bundle used by every module of the instruction decoder.
package ifd_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int RA_W    = 5;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = INSTR_W - OPC_W;
    localparam int FN_LSB  = 0;

    localparam logic [OPC_W-1:0] OP_REG  = 6'd0;
    localparam logic [OPC_W-1:0] OP_J    = 6'd2;
    localparam logic [OPC_W-1:0] OP_JAL  = 6'd3;
    localparam logic [OPC_W-1:0] OP_BEQ  = 6'd4;
    localparam logic [OPC_W-1:0] OP_BNE  = 6'd5;
    localparam logic [OPC_W-1:0] OP_ADDI = 6'd8;
    localparam logic [OPC_W-1:0] OP_SLTI = 6'd10;
    localparam logic [OPC_W-1:0] OP_ANDI = 6'd12;
    localparam logic [OPC_W-1:0] OP_ORI  = 6'd13;
    localparam logic [OPC_W-1:0] OP_LUI  = 6'd15;
    localparam logic [OPC_W-1:0] OP_LW   = 6'd35;
    localparam logic [OPC_W-1:0] OP_SW   = 6'd43;

    localparam logic [FN_W-1:0] FN_SLL = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL = 6'd2;
    localparam logic [FN_W-1:0] FN_JR  = 6'd8;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB = 6'd34;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_NOR = 6'd39;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_AND  = 4'd2,
        ALU_OR   = 4'd3,
        ALU_NOR  = 4'd4,
        ALU_SLT  = 4'd5,
        ALU_SLL  = 4'd6,
        ALU_SRL  = 4'd7,
        ALU_PASS = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    alu_imm;
        alu_op_e alu_op;
        logic    mem_rd;
        logic    mem_wr;
        logic    mem_to_reg;
        logic    branch;
        logic    branch_ne;
        logic    jump;
        logic    link;
        logic    jump_reg;
        logic    imm_zext;
        logic    imm_upper;
        logic    illegal;
    } ctrl_t;
endpackage

// File: rtl/ifd_func_ctrl.sv
// Function-field decoder for register-format words.
// Assumes: only consulted when the opcode selects the register format;
// reports whether the function code is defined and whether it is a
// jump through register.
module ifd_func_ctrl
    import ifd_pkg::*;
(
    input  logic [FN_W-1:0] funct_i,
    output alu_op_e         alu_op_o,
    output logic            valid_o,
    output logic            is_jr_o
);
    // Map each defined function code to its ALU operation.
    always_comb begin
        alu_op_o = ALU_ADD;
        valid_o  = 1'b1;
        is_jr_o  = 1'b0;
        unique case (funct_i)
            FN_ADD:  alu_op_o = ALU_ADD;
            FN_SUB:  alu_op_o = ALU_SUB;
            FN_AND:  alu_op_o = ALU_AND;
            FN_OR:   alu_op_o = ALU_OR;
            FN_NOR:  alu_op_o = ALU_NOR;
            FN_SLT:  alu_op_o = ALU_SLT;
            FN_SLL:  alu_op_o = ALU_SLL;
            FN_SRL:  alu_op_o = ALU_SRL;
            FN_JR:   is_jr_o  = 1'b1;
            default: valid_o  = 1'b0;
        endcase
    end

    // Guard: an undefined function code never decodes as a jump.
    always_comb begin
        // R10
        fn_undef_nojr_chk: assert (valid_o || !is_jr_o);
    end
endmodule

// File: rtl/ifd_main_ctrl.sv
// Opcode decoder: builds the control bundle from the opcode and, for the
// register format, from the function-field decoder's result.
// Assumes: the register-zero write guard is applied by the parent.
module ifd_main_ctrl
    import ifd_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  alu_op_e          fn_alu_op_i,
    input  logic             fn_valid_i,
    input  logic             fn_is_jr_i,
    output ctrl_t            ctl_o
);
    // Per-opcode control generation; undefined codes leave all controls low.
    always_comb begin
        ctl_o = '0;
        unique case (opcode_i)
            OP_REG: begin
                if (!fn_valid_i) begin
                    ctl_o.illegal = 1'b1;
                end else if (fn_is_jr_i) begin
                    ctl_o.jump_reg = 1'b1;
                end else begin
                    ctl_o.reg_we = 1'b1;
                    ctl_o.alu_op = fn_alu_op_i;
                end
            end
            OP_ADDI: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.alu_imm = 1'b1;
            end
            OP_SLTI: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.alu_imm = 1'b1;
                ctl_o.alu_op  = ALU_SLT;
            end
            OP_ANDI: begin
                ctl_o.reg_we   = 1'b1;
                ctl_o.alu_imm  = 1'b1;
                ctl_o.alu_op   = ALU_AND;
                ctl_o.imm_zext = 1'b1;
            end
            OP_ORI: begin
                ctl_o.reg_we   = 1'b1;
                ctl_o.alu_imm  = 1'b1;
                ctl_o.alu_op   = ALU_OR;
                ctl_o.imm_zext = 1'b1;
            end
            OP_LUI: begin
                ctl_o.reg_we    = 1'b1;
                ctl_o.alu_imm   = 1'b1;
                ctl_o.alu_op    = ALU_PASS;
                ctl_o.imm_upper = 1'b1;
            end
            OP_LW: begin
                ctl_o.reg_we     = 1'b1;
                ctl_o.alu_imm    = 1'b1;
                ctl_o.mem_rd     = 1'b1;
                ctl_o.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctl_o.alu_imm = 1'b1;
                ctl_o.mem_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctl_o.branch = 1'b1;
                ctl_o.alu_op = ALU_SUB;
            end
            OP_BNE: begin
                ctl_o.branch    = 1'b1;
                ctl_o.branch_ne = 1'b1;
                ctl_o.alu_op    = ALU_SUB;
            end
            OP_J:    ctl_o.jump = 1'b1;
            OP_JAL: begin
                ctl_o.jump   = 1'b1;
                ctl_o.link   = 1'b1;
                ctl_o.reg_we = 1'b1;
            end
            default: ctl_o.illegal = 1'b1;
        endcase
    end

    // Guards on the bundle this decoder hands to the parent.
    always_comb begin
        // R10
        illegal_quiet_chk: assert (!ctl_o.illegal ||
            !(ctl_o.reg_we || ctl_o.mem_wr || ctl_o.mem_rd || ctl_o.branch ||
              ctl_o.jump || ctl_o.link || ctl_o.jump_reg || ctl_o.alu_imm));
        // R5
        mem_excl_chk: assert (!(ctl_o.mem_rd && ctl_o.mem_wr));
        // R6
        bne_in_branch_chk: assert (!ctl_o.branch_ne || ctl_o.branch);
    end
endmodule

// File: rtl/ifd_fields.sv
// Field splitter and immediate extender.
// Assumes: the extension mode flags are mutually exclusive; with neither
// set the immediate is sign-extended.
module ifd_fields
    import ifd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               imm_zext_i,
    input  logic               imm_upper_i,
    output logic [OPC_W-1:0]   opcode_o,
    output logic [FN_W-1:0]    funct_o,
    output logic [RA_W-1:0]    rs_o,
    output logic [RA_W-1:0]    rt_o,
    output logic [RA_W-1:0]    rd_o,
    output logic [RA_W-1:0]    shamt_o,
    output logic [TGT_W-1:0]   target_o,
    output logic [INSTR_W-1:0] imm_o
);
    localparam int RT_LSB = IMM_W;
    localparam int RS_LSB = RT_LSB + RA_W;
    localparam int RD_LSB = IMM_W - RA_W;
    localparam int SH_LSB = RD_LSB - RA_W;
    localparam int PAD_W  = INSTR_W - IMM_W;

    logic [IMM_W-1:0] raw_imm;

    // Slice the fixed fields shared by all three formats.
    always_comb begin
        opcode_o = instr_i[INSTR_W-1 -: OPC_W];
        rs_o     = instr_i[RS_LSB +: RA_W];
        rt_o     = instr_i[RT_LSB +: RA_W];
        rd_o     = instr_i[RD_LSB +: RA_W];
        shamt_o  = instr_i[SH_LSB +: RA_W];
        funct_o  = instr_i[FN_LSB +: FN_W];
        target_o = instr_i[TGT_W-1:0];
        raw_imm  = instr_i[IMM_W-1:0];
    end

    // Widen the 16-bit constant by the selected rule.
    always_comb begin
        if (imm_upper_i)
            imm_o = {raw_imm, {PAD_W{1'b0}}};
        else if (imm_zext_i)
            imm_o = {{PAD_W{1'b0}}, raw_imm};
        else
            imm_o = {{PAD_W{raw_imm[IMM_W-1]}}, raw_imm};
    end

    // Guard: the low half of the instruction always survives extension.
    always_comb begin
        // R4
        imm_low_keep_chk: assert (imm_upper_i || imm_o[IMM_W-1:0] == instr_i[IMM_W-1:0]);
    end
endmodule

// File: rtl/instr_decoder.sv
// Top of the three-format instruction decoder.
// Purely combinational; selects the write address and blocks writes to
// register 0 on top of the opcode and function decoders.
module instr_decoder
    import ifd_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic [31:0] instr_i,
    output logic [4:0]  rs_o,
    output logic [4:0]  rt_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  shamt_o,
    output logic [25:0] jtarget_o,
    output logic [31:0] imm_o,
    output logic [4:0]  wr_addr_o,
    output logic        reg_we_o,
    output logic        alu_src_imm_o,
    output logic [3:0]  alu_op_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        mem_to_reg_o,
    output logic        branch_o,
    output logic        branch_ne_o,
    output logic        jump_o,
    output logic        link_o,
    output logic        jump_reg_o,
    output logic        illegal_o
);
    localparam logic [RA_W-1:0] LINK_ADDR = RA_W'(LINK_REG);

    logic [OPC_W-1:0] opcode;
    logic [FN_W-1:0]  funct;
    alu_op_e          fn_alu_op;
    logic             fn_valid;
    logic             fn_is_jr;
    ctrl_t            ctl;

    ifd_fields u_fields (
        .instr_i     (instr_i),
        .imm_zext_i  (ctl.imm_zext),
        .imm_upper_i (ctl.imm_upper),
        .opcode_o    (opcode),
        .funct_o     (funct),
        .rs_o        (rs_o),
        .rt_o        (rt_o),
        .rd_o        (rd_o),
        .shamt_o     (shamt_o),
        .target_o    (jtarget_o),
        .imm_o       (imm_o)
    );

    ifd_func_ctrl u_func (
        .funct_i  (funct),
        .alu_op_o (fn_alu_op),
        .valid_o  (fn_valid),
        .is_jr_o  (fn_is_jr)
    );

    ifd_main_ctrl u_main (
        .opcode_i    (opcode),
        .fn_alu_op_i (fn_alu_op),
        .fn_valid_i  (fn_valid),
        .fn_is_jr_i  (fn_is_jr),
        .ctl_o       (ctl)
    );

    // Pick the destination by format: rd, link register or rt.
    always_comb begin
        if (opcode == OP_REG)      wr_addr_o = rd_o;
        else if (opcode == OP_JAL) wr_addr_o = LINK_ADDR;
        else                       wr_addr_o = rt_o;
    end

    // Drive the control ports; register 0 is never written.
    always_comb begin
        reg_we_o      = ctl.reg_we && (wr_addr_o != '0);
        alu_src_imm_o = ctl.alu_imm;
        alu_op_o      = ctl.alu_op;
        mem_rd_o      = ctl.mem_rd;
        mem_wr_o      = ctl.mem_wr;
        mem_to_reg_o  = ctl.mem_to_reg;
        branch_o      = ctl.branch;
        branch_ne_o   = ctl.branch_ne;
        jump_o        = ctl.jump;
        link_o        = ctl.link;
        jump_reg_o    = ctl.jump_reg;
        illegal_o     = ctl.illegal;
    end

    // Port-level guards.
    always_comb begin
        // R9
        zero_reg_guard_chk: assert (!(reg_we_o && wr_addr_o == '0));
        // R7
        link_dest_chk: assert (!link_o || (jump_o && wr_addr_o == LINK_ADDR));
        // R8
        jr_no_write_chk: assert (!jump_reg_o || !(reg_we_o || mem_wr_o || jump_o));
    end
endmodule

// File: tb/instr_decoder_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// corner cases for immediate extension and the zero instruction.
module instr_decoder_bench;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] instr;
    logic [4:0]  rs, rt, rd, shamt, wr_addr;
    logic [25:0] jtarget;
    logic [31:0] imm;
    logic        reg_we, alu_src_imm, mem_rd, mem_wr, mem_to_reg;
    logic        branch, branch_ne, jump, link, jump_reg, illegal;
    logic [3:0]  alu_op;

    instr_decoder u_instr_decoder (
        .instr_i(instr), .rs_o(rs), .rt_o(rt), .rd_o(rd), .shamt_o(shamt),
        .jtarget_o(jtarget), .imm_o(imm), .wr_addr_o(wr_addr),
        .reg_we_o(reg_we), .alu_src_imm_o(alu_src_imm), .alu_op_o(alu_op),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_to_reg_o(mem_to_reg),
        .branch_o(branch), .branch_ne_o(branch_ne), .jump_o(jump),
        .link_o(link), .jump_reg_o(jump_reg), .illegal_o(illegal)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [31:0] rfmt(input int s, input int t, input int d,
                                         input int sh, input int fn);
        return {6'd0, 5'(s), 5'(t), 5'(d), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] ifmt(input int op, input int s, input int t,
                                         input int k);
        return {6'(op), 5'(s), 5'(t), 16'(k)};
    endfunction
    function automatic logic [31:0] jfmt(input int op, input int tg);
        return {6'(op), 26'(tg)};
    endfunction
    // control pack: we, wr_addr, alu_src_imm, alu_op, then flags
    // {mem_rd, mem_wr, mem_to_reg, branch, branch_ne, jump, link, jump_reg, illegal}
    function automatic logic [19:0] c(input logic we, input int wa, input logic src,
                                      input int op, input logic [8:0] fl);
        return {we, 5'(wa), src, 4'(op), fl};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [19:0] ctl;
        logic [1:0]  ext;   // 0 sign, 1 zero, 2 upper
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{rfmt(1,2,3,0,32),       c(1,3,0,0,9'b0),          2'd0, 4'd2},  // R2 add
        '{rfmt(4,5,6,0,34),       c(1,6,0,1,9'b0),          2'd0, 4'd2},  // R2 sub
        '{rfmt(7,8,9,0,36),       c(1,9,0,2,9'b0),          2'd0, 4'd2},  // R2 and
        '{rfmt(1,1,17,0,37),      c(1,17,0,3,9'b0),         2'd0, 4'd2},  // R2 or
        '{rfmt(2,3,18,0,39),      c(1,18,0,4,9'b0),         2'd0, 4'd2},  // R2 nor
        '{rfmt(4,5,19,0,42),      c(1,19,0,5,9'b0),         2'd0, 4'd2},  // R2 slt
        '{rfmt(0,11,10,5,0),      c(1,10,0,6,9'b0),         2'd0, 4'd2},  // R2 sll
        '{rfmt(0,13,12,31,2),     c(1,12,0,7,9'b0),         2'd0, 4'd2},  // R2 srl
        '{ifmt(8,1,2,16'hFFFC),   c(1,2,1,0,9'b0),          2'd0, 4'd3},  // R3 addi
        '{ifmt(10,3,4,16'h8000),  c(1,4,1,5,9'b0),          2'd0, 4'd3},  // R3 slti
        '{ifmt(12,5,6,16'hF0F0),  c(1,6,1,2,9'b0),          2'd1, 4'd4},  // R4 andi
        '{ifmt(13,5,7,16'h8001),  c(1,7,1,3,9'b0),          2'd1, 4'd4},  // R4 ori
        '{ifmt(15,0,8,16'h003D),  c(1,8,1,8,9'b0),          2'd2, 4'd4},  // R4 lui
        '{ifmt(35,9,10,16'h0020), c(1,10,1,0,9'b101000000), 2'd0, 4'd5},  // R5 lw
        '{ifmt(43,9,11,16'hFFD0), c(0,11,1,0,9'b010000000), 2'd0, 4'd5},  // R5 sw
        '{ifmt(4,1,2,16'hFFFF),   c(0,2,0,1,9'b000100000),  2'd0, 4'd6},  // R6 beq
        '{ifmt(5,3,4,16'h0019),   c(0,4,0,1,9'b000110000),  2'd0, 4'd6},  // R6 bne
        '{jfmt(2,26'h3FFFFFF),    c(0,31,0,0,9'b000001000), 2'd0, 4'd7},  // R7 j
        '{jfmt(3,26'h0000271),    c(1,31,0,0,9'b000001100), 2'd0, 4'd7},  // R7 jal
        '{rfmt(31,0,0,0,8),       c(0,0,0,0,9'b000000010),  2'd0, 4'd8},  // R8 jr
        '{rfmt(1,2,0,0,32),       c(0,0,0,0,9'b0),          2'd0, 4'd9},  // R9 add to r0
        '{ifmt(8,1,0,16'h0005),   c(0,0,1,0,9'b0),          2'd0, 4'd9},  // R9 addi to r0
        '{ifmt(35,2,0,16'h0004),  c(0,0,1,0,9'b101000000),  2'd0, 4'd9},  // R9 lw to r0
        '{ifmt(43,2,0,16'h0004),  c(0,0,1,0,9'b010000000),  2'd0, 4'd9},  // R9 sw of r0
        '{ifmt(63,1,2,16'h1234),  c(0,2,0,0,9'b000000001),  2'd0, 4'd10}, // R10 op 63
        '{ifmt(1,0,5,16'h0000),   c(0,5,0,0,9'b000000001),  2'd0, 4'd10}, // R10 op 1
        '{rfmt(1,2,3,0,1),        c(0,3,0,0,9'b000000001),  2'd0, 4'd10}, // R10 funct 1
        '{rfmt(0,0,0,0,63),       c(0,0,0,0,9'b000000001),  2'd0, 4'd10}  // R10 funct 63
    };

    function automatic logic [31:0] exp_imm(input logic [31:0] w, input logic [1:0] e);
        case (e)
            2'd1:    return {16'h0000, w[15:0]};
            2'd2:    return {w[15:0], 16'h0000};
            default: return {{16{w[15]}}, w[15:0]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (instr %h)", tag, act, exp, instr);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        instr = w;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        instr = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Zero word (shift of r0 into r0): legal, writes nothing. R9
        apply(32'h0);
        check("R9 zero word we", {31'd0, reg_we}, 32'd0);
        check("R10 zero word legal", {31'd0, illegal}, 32'd0);

        // Table walk: controls, immediate and raw fields per vector.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].ins);
            check($sformatf("R%0d controls #%0d", VEC[i].req, i),
                  {12'd0, reg_we, wr_addr, alu_src_imm, alu_op, mem_rd, mem_wr,
                   mem_to_reg, branch, branch_ne, jump, link, jump_reg, illegal},
                  {12'd0, VEC[i].ctl});
            check($sformatf("R4 imm #%0d", i), imm, exp_imm(VEC[i].ins, VEC[i].ext));
            // R1 field extraction
            check($sformatf("R1 fields #%0d", i),
                  {2'd0, rs, rt, rd, shamt, VEC[i].ins[5:0]},
                  {2'd0, VEC[i].ins[25:6], VEC[i].ins[5:0]});
            check($sformatf("R1 target #%0d", i), {6'd0, jtarget}, {6'd0, VEC[i].ins[25:0]});
        end

        // Extension boundaries. R4
        apply(ifmt(8, 1, 2, 16'h7FFF));
        check("R4 addi max positive", imm, 32'h00007FFF);
        apply(ifmt(12, 1, 2, 16'hFFFF));
        check("R4 andi all ones", imm, 32'h0000FFFF);
        apply(ifmt(15, 0, 3, 16'hFFFF));
        check("R4 lui all ones", imm, 32'hFFFF0000);
        apply(ifmt(4, 1, 2, 16'h8000));
        check("R4 branch min offset", imm, 32'hFFFF8000);

        // Link address with rt field nonzero still goes to 31. R7
        apply({6'd3, 5'd4, 5'd9, 16'h0});
        check("R7 jal dest", {27'd0, wr_addr}, 32'd31);

        // Register-format writes rd even when rt differs. R2
        apply(rfmt(3, 30, 29, 0, 32));
        check("R2 dest is rd", {27'd0, wr_addr}, 32'd29);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule